// File: doc/BRIEF.md
# Banked Synchronous SRAM with Word and Width Expansion

This block is a clocked memory assembled from several identical small banks. Each bank holds 2^BANK_AW words of NIB_W bits. The upper SEL_W address bits feed a decoder, and the decoder gives each bank its own active-low select. The lower BANK_AW address bits and the write data are shared by every bank. With the defaults this yields 4096 words of 4 bits from four 1024-word banks.

Setting LANES above one places that many banks next to each other on the same select and address. Each of these banks stores one NIB_W-bit slice of a wider word, so LANES=2 turns the array into 4096 words of 8 bits.

Every control input is active low and is sampled on the rising clock edge, together with the address and the write data:
- With select high, the cycle does nothing.
- With select low and write enable low, the addressed word is overwritten.
- With select low and output enable low, the addressed word appears on the read port one cycle later. Otherwise the read port shows zero.

The read port is driven by a multiplexer, not by tri-state lines. The pins are level controls, not a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `banked_sram`

## Requirements
- R1: After reset is released, rdata reads zero until a read cycle has completed.
- R2: Address bits [BANK_AW+SEL_W-1:BANK_AW] choose the bank. With the defaults, value 0 picks bank 0, 1 picks bank 1, 2 picks bank 2 and 3 picks bank 3. Bits [BANK_AW-1:0] pick the word inside that bank.
- R3: In any cycle, at most one bank select is active, and only when cs_n is low. A write therefore changes one word of one bank and leaves the other banks unchanged.
- R4: A rising edge with cs_n=0 and we_n=0 stores wdata at addr.
- R5: A rising edge with cs_n=0 and oe_n=0 places the word stored at addr on rdata. It stays there until the next rising edge.
- R6: A rising edge with oe_n=1 makes rdata zero for the following cycle, and the stored contents are not changed.
- R7: A rising edge with cs_n=1 writes nothing, whatever we_n is, and makes rdata zero for the following cycle.
- R8: When a cycle both writes and reads the same address, rdata shows the contents from before the write. A later read shows the new data.
- R9: With LANES=2, wdata[3:0] goes to one bank and wdata[7:4] goes to a second bank on the same address, and an 8-bit word reads back intact.
- R10: A write with oe_n=1 still stores its data, and rdata is zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the read path |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | BANK_AW+SEL_W | Word address; the upper SEL_W bits pick the bank |
| wdata | input | NIB_W*LANES | Write data |
| rdata | output | NIB_W*LANES | Read data, one cycle after the access; zero when no read took place |

## Verification
The bench builds the block with BANK_AW=10, SEL_W=2, NIB_W=4 and LANES=2. That gives four banks on the decoder, each made of two side-by-side nibble banks.

With this build, one write can show whether both nibble lanes land at the same address. The bank decoder can be driven across each 1024-word boundary of the 4096-word space. Keeping the full bank depth also places the boundary addresses 0x3FF/0x400, 0x7FF/0x800 and 0xBFF/0xC00 where the decode bits flip.

// File: rtl/xs_pkg.sv
package xs_pkg;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
  } xs_ctl_t;

  function automatic logic do_write(input xs_ctl_t c);
    return (!c.cs_n) && (!c.we_n);
  endfunction

  function automatic logic do_read(input xs_ctl_t c);
    return (!c.cs_n) && (!c.oe_n);
  endfunction

endpackage

// File: rtl/xs_decode.sv
module xs_decode #(
  parameter int SEL_W = 2,
  localparam int BANKS = 1 << SEL_W
) (
  input  logic             en_n,
  input  logic [SEL_W-1:0] sel,
  output logic [BANKS-1:0] cs_n_vec
);

  for (genvar i = 0; i < BANKS; i++) begin : g_line
    assign cs_n_vec[i] = en_n | (sel != SEL_W'(i));
  end

endmodule

// File: rtl/xs_bank.sv
module xs_bank #(
  parameter int AW = 10,
  parameter int DW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] cells [DEPTH];

  // storage: write only when both select and write enable are low
  always_ff @(posedge clk) begin
    if (!cs_n && !we_n) cells[addr] <= din;
  end

  // read register: sees the pre-write contents on a simultaneous write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dout <= '0;
    else if (!cs_n && !oe_n)   dout <= cells[addr];
    else                       dout <= '0;
  end

endmodule

// File: rtl/xs_rmux.sv
module xs_rmux #(
  parameter int SEL_W = 2,
  parameter int DW    = 4,
  localparam int BANKS = 1 << SEL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic [SEL_W-1:0]          sel,
  input  logic [BANKS-1:0][DW-1:0]  bank_q,
  output logic [DW-1:0]             q
);

  logic [SEL_W-1:0] sel_q;

  // remember which bank answered the access of the last edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (take)  sel_q <= sel;
  end

  assign q = bank_q[sel_q];

endmodule

// File: rtl/banked_sram.sv
module banked_sram #(
  parameter int BANK_AW = 10,
  parameter int SEL_W   = 2,
  parameter int NIB_W   = 4,
  parameter int LANES   = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       we_n,
  input  logic                       oe_n,
  input  logic [BANK_AW+SEL_W-1:0]   addr,
  input  logic [NIB_W*LANES-1:0]     wdata,
  output logic [NIB_W*LANES-1:0]     rdata
);
  import xs_pkg::*;

  localparam int AW    = BANK_AW + SEL_W;
  localparam int DW    = NIB_W * LANES;
  localparam int BANKS = 1 << SEL_W;

  xs_ctl_t ctl;
  assign ctl = '{cs_n: cs_n, we_n: we_n, oe_n: oe_n};

  logic [SEL_W-1:0]          bank_sel;
  logic [BANKS-1:0]          bank_cs_n;
  logic [BANKS-1:0][DW-1:0]  bank_q;

  assign bank_sel = addr[AW-1 -: SEL_W];

  xs_decode #(.SEL_W(SEL_W)) u_dec (
    .en_n     (ctl.cs_n),
    .sel      (bank_sel),
    .cs_n_vec (bank_cs_n)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      xs_bank #(.AW(BANK_AW), .DW(NIB_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (bank_cs_n[b]),
        .we_n  (ctl.we_n),
        .oe_n  (ctl.oe_n),
        .addr  (addr[BANK_AW-1:0]),
        .din   (wdata[l*NIB_W +: NIB_W]),
        .dout  (bank_q[b][l*NIB_W +: NIB_W])
      );
    end
  end

  xs_rmux #(.SEL_W(SEL_W), .DW(DW)) u_mux (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (do_read(ctl)),
    .sel    (bank_sel),
    .bank_q (bank_q),
    .q      (rdata)
  );

endmodule

// File: rtl/banked_sram_chk.sv
module banked_sram_chk #(
  parameter int BANK_AW = 10,
  parameter int SEL_W   = 2,
  parameter int DW      = 4,
  localparam int AW     = BANK_AW + SEL_W,
  localparam int BANKS  = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             oe_n,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    rdata,
  input logic [BANKS-1:0] bank_cs_n
);

  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bank_cs_n));

  assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (&bank_cs_n));

  assert_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !bank_cs_n[addr[AW-1 -: SEL_W]]);

  assert_oe_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (rdata == '0));

  assert_desel_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (rdata == '0));

endmodule

bind banked_sram banked_sram_chk #(
  .BANK_AW (BANK_AW),
  .SEL_W   (SEL_W),
  .DW      (NIB_W*LANES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .addr      (addr),
  .rdata     (rdata),
  .bank_cs_n (bank_cs_n)
);

// File: tb/sim_banked_sram.sv
`timescale 1ns/1ps
module sim_banked_sram;

  localparam int BANK_AW = 10;
  localparam int SEL_W   = 2;
  localparam int NIB_W   = 4;
  localparam int LANES   = 2;
  localparam int AW      = BANK_AW + SEL_W;
  localparam int DW      = NIB_W * LANES;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  banked_sram #(.BANK_AW(BANK_AW), .SEL_W(SEL_W), .NIB_W(NIB_W), .LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: rdata=%h expected=%h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic c, input logic w, input logic o,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs_n = c; we_n = w; oe_n = o; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    cyc(1'b0, 1'b1, 1'b0, a, '0);
    check(req, rdata, exp);
  endtask

  task automatic t_reset();
    check("R1", rdata, '0);
    cyc(1'b1, 1'b1, 1'b1, '0, '0);
    check("R1", rdata, '0);
  endtask

  task automatic t_bank_decode();
    for (int b = 0; b < 4; b++) wr({2'(b), 10'h155}, 8'h10 + 8'(b * 17));
    for (int b = 0; b < 4; b++) rd_check("R2_R3_R5", {2'(b), 10'h155}, 8'h10 + 8'(b * 17));
  endtask

  task automatic t_width();
    wr(12'h3FF, 8'hA5);
    wr(12'hC00, 8'h5A);
    rd_check("R9", 12'h3FF, 8'hA5);
    rd_check("R9", 12'hC00, 8'h5A);
  endtask

  task automatic t_boundaries();
    logic [AW-1:0] pts [8] = '{12'h000, 12'h3FF, 12'h400, 12'h7FF,
                               12'h800, 12'hBFF, 12'hC00, 12'hFFF};
    for (int i = 0; i < 8; i++) wr(pts[i], 8'hC0 | 8'(i));
    for (int i = 0; i < 8; i++) rd_check("R2_R4", pts[i], 8'hC0 | 8'(i));
  endtask

  task automatic t_oe();
    wr(12'h123, 8'h3C);
    cyc(1'b0, 1'b1, 1'b1, 12'h123, '0);
    check("R6", rdata, '0);
    rd_check("R6", 12'h123, 8'h3C);
  endtask

  task automatic t_deselect();
    wr(12'h456, 8'h77);
    cyc(1'b1, 1'b0, 1'b0, 12'h456, 8'hFF);
    check("R7", rdata, '0);
    rd_check("R7", 12'h456, 8'h77);
  endtask

  task automatic t_read_during_write();
    wr(12'h9AB, 8'h11);
    cyc(1'b0, 1'b0, 1'b0, 12'h9AB, 8'hEE);
    check("R8", rdata, 8'h11);
    rd_check("R8", 12'h9AB, 8'hEE);
  endtask

  task automatic t_write_silent();
    cyc(1'b0, 1'b0, 1'b1, 12'hDEF, 8'h69);
    check("R10", rdata, '0);
    rd_check("R10", 12'hDEF, 8'h69);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bank_decode();
    t_width();
    t_boundaries();
    t_oe();
    t_deselect();
    t_read_during_write();
    t_write_silent();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule